// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block sits beside the host side of an SMBus controller and listens for the one frame in which another device on the bus becomes the controller and talks to the host: a write to the host address 7'h08. That frame carries three bytes: the sender's own address, then the low and then the high half of a 16-bit notify word. The receiver acknowledges each byte. When the frame closes with a STOP, it copies the three bytes into read-only registers and raises a sticky notify flag. An interrupt follows when software has enabled it.

SCL and SDA come in as raw pin levels. Each passes through a synchroniser and a glitch filter before START, STOP and bit edges are decoded. The only drive back onto the bus is an open-drain pull-down of SDA during acknowledge slots. Software reads the captured values and the flag through a byte-wide register port. It clears the flag by writing a 1 to it, and that reopens the receiver for the next notify.

Top module: `hnotify_rx`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is 0 and `sdaOe` is 0.
- R2: A complete notify frame (START, byte 0x10, three data bytes, STOP) loads register 2 with the first data byte with bit 0 forced to 0 (sender address in bits 7:1). It loads register 3 with the second byte (word low) and register 4 with the third byte (word high), and sets bit 0 of register 0 (notify flag).
- R3: The receiver pulls SDA low (`sdaOe`=1) through the acknowledge clock that follows the address byte and each of the three data bytes of an accepted frame.
- R4: An address byte other than 0x10 is not acknowledged. This includes 7'h08 with the read bit set. Such a frame changes no register.
- R5: Writing a value with bit 0 set to register 0 clears the notify flag. Writing a value with bit 0 clear leaves the flag unchanged.
- R6: Register 1 bit 0 is a read/write interrupt enable, and `irq` is high exactly while both the flag and the enable are set.
- R7: While the flag is set, a new notify frame is not acknowledged at its address byte, and registers 2 to 4 keep their values.
- R8: A frame that carries fewer than three data bytes before its STOP is discarded: the flag stays clear. A frame that carries more than three is also discarded: its fourth byte is not acknowledged and the flag stays clear.
- R9: A repeated START before the frame's STOP discards the bytes received so far. The frame that follows that START is decoded normally.
- R10: A pulse on SCL shorter than `FILT_CYC` clock cycles is ignored: a frame with such a glitch inside a bit is captured unchanged.
- R11: Registers 2, 3 and 4 are read-only: writes to them leave their contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| sdaOe | output | 1 | 1 = pull SDA low (acknowledge) |
| regAddr | input | 3 | Register select: 0 status, 1 control, 2 sender address, 3 word low, 4 word high |
| regWr | input | 1 | Write strobe, takes effect at the next clock edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| irq | output | 1 | Notify interrupt |

## Verification
A pin edge reaches the decoder only after the two synchroniser flops and `FILT_CYC` filter cycles, plus one edge-detect register: about six cycles at default settings. The captured registers and the flag therefore change about seven cycles after the SDA rise that forms the STOP. The bench holds the bus idle for sixteen cycles after each STOP before it reads anything. The acknowledge pull-down appears about six cycles after the eighth SCL fall. The bench samples it in the middle of the ninth clock's high phase, which lies well after that point and well before the release. Register writes land at the next edge, so each read-back is taken at the following falling clock edge.

// File: rtl/hn_pkg.sv
package hn_pkg;
  localparam int DW = 8;
  localparam int REG_AW = 3;
  localparam int NBYTES = 3;
  localparam int IDXW = 2;
  localparam logic [6:0] HOST_ADDR = 7'h08;

  localparam logic [REG_AW-1:0] REG_STAT = 3'd0;
  localparam logic [REG_AW-1:0] REG_CTRL = 3'd1;
  localparam logic [REG_AW-1:0] REG_NADDR = 3'd2;
  localparam logic [REG_AW-1:0] REG_NDLO = 3'd3;
  localparam logic [REG_AW-1:0] REG_NDHI = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_SKIP
  } hnState_t;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
    logic [IDXW-1:0] loadIdx;
    logic commit;
  } hnStrobe_t;
endpackage

// File: rtl/hn_filter.sv
module hn_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0] cnt;
  logic syncBit;

  assign syncBit = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= 1'b1;
      cnt <= '0;
    end else if (syncBit == filtOut) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_CYC - 1)) begin
      filtOut <= syncBit;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (filtOut != $past(filtOut)) |-> ($past(syncBit) == filtOut)); // R10
endmodule

// File: rtl/hn_ctrl.sv
module hn_ctrl
  import hn_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclF,
  input  logic sdaF,
  input  logic [DW-1:0] rxByte,
  input  logic flagQ,
  output hnStrobe_t stb,
  output logic sdaOe
);
  hnState_t st, stN;
  logic [3:0] bitCnt, bitN;
  logic [IDXW-1:0] byteIdx, idxN;
  logic sclQ, sdaQ, sdaOeQ, oeN;
  logic sclRise, sclFall, startEv, stopEv;

  assign sclRise = sclF & ~sclQ;
  assign sclFall = ~sclF & sclQ;
  assign startEv = sclF & sclQ & sdaQ & ~sdaF;
  assign stopEv  = sclF & sclQ & ~sdaQ & sdaF;
  assign sdaOe = sdaOeQ;

  always_comb begin
    stN = st;
    bitN = bitCnt;
    idxN = byteIdx;
    oeN = sdaOeQ;
    stb = '0;
    if (startEv) begin
      stN = ST_ADDR;
      bitN = '0;
      idxN = '0;
      oeN = 1'b0;
    end else if (stopEv) begin
      if (st == ST_DATA && byteIdx == IDXW'(NBYTES) && bitCnt <= 4'd1)
        stb.commit = 1'b1;
      stN = ST_IDLE;
      oeN = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_DATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.shiftEn = 1'b1;
            stb.shiftBit = sdaF;
            bitN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (st == ST_ADDR) begin
              if (rxByte == {HOST_ADDR, 1'b0} && !flagQ) begin
                stN = ST_AACK;
                oeN = 1'b1;
              end else begin
                stN = ST_SKIP;
              end
            end else if (byteIdx != IDXW'(NBYTES)) begin
              stb.loadEn = 1'b1;
              stb.loadIdx = byteIdx;
              idxN = byteIdx + 1'b1;
              stN = ST_DACK;
              oeN = 1'b1;
            end else begin
              stN = ST_SKIP;
            end
          end
        end
        ST_AACK, ST_DACK: begin
          if (sclFall) begin
            oeN = 1'b0;
            stN = ST_DATA;
            bitN = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      bitCnt <= '0;
      byteIdx <= '0;
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      sdaOeQ <= 1'b0;
    end else begin
      st <= stN;
      bitCnt <= bitN;
      byteIdx <= idxN;
      sclQ <= sclF;
      sdaQ <= sdaF;
      sdaOeQ <= oeN;
    end
  end

  AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOeQ) |-> !sclF); // R3
  AST_NACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR && sclFall && bitCnt == 4'd8 && flagQ) |=> !sdaOeQ); // R7
  AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (st == ST_ADDR && byteIdx == '0)); // R9
endmodule

// File: rtl/hn_dp.sv
module hn_dp
  import hn_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  hnStrobe_t stb,
  input  logic [REG_AW-1:0] regAddr,
  input  logic regWr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] rxByte,
  output logic flagQ,
  output logic [DW-1:0] regRdata,
  output logic irq
);
  logic [DW-1:0] stgQ [NBYTES];
  logic [DW-1:0] naddrQ, ndLoQ, ndHiQ;
  logic ienQ;
  logic clrReq;
  logic unusedWbits;

  assign unusedWbits = ^regWdata[DW-1:1];
  assign clrReq = regWr && regAddr == REG_STAT && regWdata[0];
  assign irq = flagQ & ienQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (stb.shiftEn) rxByte <= {rxByte[DW-2:0], stb.shiftBit};
  end

  for (genvar g = 0; g < NBYTES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stgQ[g] <= '0;
      else if (stb.loadEn && stb.loadIdx == IDXW'(g)) stgQ[g] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      naddrQ <= '0;
      ndLoQ <= '0;
      ndHiQ <= '0;
      flagQ <= 1'b0;
      ienQ <= 1'b0;
    end else begin
      if (stb.commit) begin
        naddrQ <= {stgQ[0][DW-1:1], 1'b0};
        ndLoQ <= stgQ[1];
        ndHiQ <= stgQ[2];
        flagQ <= 1'b1;
      end else if (clrReq) begin
        flagQ <= 1'b0;
      end
      if (regWr && regAddr == REG_CTRL) ienQ <= regWdata[0];
    end
  end

  always_comb begin
    case (regAddr)
      REG_STAT:  regRdata = {{(DW-1){1'b0}}, flagQ};
      REG_CTRL:  regRdata = {{(DW-1){1'b0}}, ienQ};
      REG_NADDR: regRdata = naddrQ;
      REG_NDLO:  regRdata = ndLoQ;
      REG_NDHI:  regRdata = ndHiQ;
      default:   regRdata = '0;
    endcase
  end

  AST_COMMIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> flagQ); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !stb.commit) |=> !flagQ); // R5
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ); // R5
  AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    flagQ |=> ($stable(naddrQ) && $stable(ndLoQ) && $stable(ndHiQ))); // R7
endmodule

// File: rtl/hnotify_rx.sv
module hnotify_rx
  import hn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic regWr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic irq
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] rawVec, filtVec;
  hnStrobe_t stb;
  logic [DW-1:0] rxByte;
  logic flagQ;

  assign rawVec = {sdaIn, sclIn};

  for (genvar g = 0; g < NLINES; g++) begin : gLine
    hn_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) i_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawVec[g]), .filtOut(filtVec[g])
    );
  end

  hn_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclF(filtVec[0]), .sdaF(filtVec[1]),
    .rxByte(rxByte), .flagQ(flagQ), .stb(stb), .sdaOe(sdaOe)
  );

  hn_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .rxByte(rxByte), .flagQ(flagQ),
    .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: tb/test_hnotify_rx.sv
module test_hnotify_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irq, sdaOe;
  logic sdaLine;
  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  localparam int Q = 8;
  localparam int H = 16;

  always #4 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  hnotify_rx i_hnotify_rx (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busStart();
    mSda = 1'b1; waitC(Q);
    mScl = 1'b1; waitC(Q);
    mSda = 1'b0; waitC(Q);
    mScl = 1'b0; waitC(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitC(Q);
    mScl = 1'b1; waitC(Q);
    mSda = 1'b1; waitC(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitC(Q);
      mScl = 1'b1;
      if (glitch && i == 3) begin
        waitC(6); mScl = 1'b0; waitC(1); mScl = 1'b1; waitC(H - 7);
      end else begin
        waitC(H);
      end
      mScl = 1'b0; waitC(Q);
    end
    mSda = 1'b1; waitC(Q);
    mScl = 1'b1; waitC(H / 2);
    ack = ~sdaLine;
    waitC(H / 2);
    mScl = 1'b0; waitC(Q);
  endtask

  task automatic sendFrame(input logic [7:0] ab, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int nData, input bit glitch,
                           input bit doStop, output logic [3:0] acks);
    bit a;
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = 8'hEE;
    acks = '0;
    busStart();
    sendByte(ab, 1'b0, a);
    acks[0] = a;
    if (a) begin
      for (int k = 0; k < nData; k++) begin
        sendByte(dv[k], glitch && k == 1, a);
        if (k < 3) acks[k+1] = a;
        else check("R8 fourth byte ack", {15'd0, a}, 16'd0);
      end
    end
    if (doStop) busStop();
  endtask

  task automatic expectRegs(input string tag, input logic [7:0] f, input logic [7:0] na,
                            input logic [7:0] lo, input logic [7:0] hi);
    logic [7:0] d;
    rd(3'd0, d); check({tag, " flag"}, {8'd0, d}, {8'd0, f});
    rd(3'd2, d); check({tag, " addr"}, {8'd0, d}, {8'd0, na});
    rd(3'd3, d); check({tag, " low"}, {8'd0, d}, {8'd0, lo});
    rd(3'd4, d); check({tag, " high"}, {8'd0, d}, {8'd0, hi});
  endtask

  task automatic tReset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", {8'd0, d}, 16'd0);
    end
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 sdaOe", {15'd0, sdaOe}, 16'd0);
  endtask

  task automatic tNotify();
    logic [3:0] acks;
    sendFrame(8'h10, 8'h5B, 8'h34, 8'h12, 3, 1'b0, 1'b1, acks);
    check("R3 acks", {12'd0, acks}, 16'h000F);
    expectRegs("R2", 8'h01, 8'h5A, 8'h34, 8'h12);
    check("R6 irq disabled", {15'd0, irq}, 16'd0);
  endtask

  task automatic tIrq();
    logic [7:0] d;
    wr(3'd1, 8'h01);
    rd(3'd1, d); check("R6 ctrl readback", {8'd0, d}, 16'h0001);
    check("R6 irq enabled", {15'd0, irq}, 16'd1);
    wr(3'd1, 8'h00);
    check("R6 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd1, 8'h01);
  endtask

  task automatic tReadOnly();
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    expectRegs("R11", 8'h01, 8'h5A, 8'h34, 8'h12);
  endtask

  task automatic tFull();
    logic [3:0] acks;
    sendFrame(8'h10, 8'h22, 8'h99, 8'h88, 3, 1'b0, 1'b1, acks);
    check("R7 address nack", {12'd0, acks}, 16'd0);
    expectRegs("R7", 8'h01, 8'h5A, 8'h34, 8'h12);
  endtask

  task automatic tW1c();
    wr(3'd0, 8'hFE);
    expectRegs("R5 write0", 8'h01, 8'h5A, 8'h34, 8'h12);
    wr(3'd0, 8'h01);
    expectRegs("R5 write1", 8'h00, 8'h5A, 8'h34, 8'h12);
    check("R6 irq after clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic tWrongAddr();
    logic [3:0] acks;
    sendFrame(8'h12, 8'h40, 8'h41, 8'h42, 3, 1'b0, 1'b1, acks);
    check("R4 other address nack", {12'd0, acks}, 16'd0);
    sendFrame(8'h11, 8'h40, 8'h41, 8'h42, 3, 1'b0, 1'b1, acks);
    check("R4 read bit nack", {12'd0, acks}, 16'd0);
    expectRegs("R4", 8'h00, 8'h5A, 8'h34, 8'h12);
  endtask

  task automatic tShortLong();
    logic [3:0] acks;
    sendFrame(8'h10, 8'h30, 8'h31, 8'h32, 2, 1'b0, 1'b1, acks);
    check("R8 short acks", {12'd0, acks}, 16'h0007);
    expectRegs("R8 short", 8'h00, 8'h5A, 8'h34, 8'h12);
    sendFrame(8'h10, 8'h30, 8'h31, 8'h32, 4, 1'b0, 1'b1, acks);
    expectRegs("R8 long", 8'h00, 8'h5A, 8'h34, 8'h12);
  endtask

  task automatic tRestart();
    logic [3:0] acks;
    sendFrame(8'h10, 8'h70, 8'h71, 8'h72, 2, 1'b0, 1'b0, acks);
    sendFrame(8'h10, 8'h44, 8'hCD, 8'hAB, 3, 1'b0, 1'b1, acks);
    check("R9 acks after restart", {12'd0, acks}, 16'h000F);
    expectRegs("R9", 8'h01, 8'h44, 8'hCD, 8'hAB);
    check("R6 irq on notify", {15'd0, irq}, 16'd1);
    wr(3'd0, 8'h01);
  endtask

  task automatic tGlitch();
    logic [3:0] acks;
    sendFrame(8'h10, 8'h66, 8'hC3, 8'h5E, 3, 1'b1, 1'b1, acks);
    check("R10 acks", {12'd0, acks}, 16'h000F);
    expectRegs("R10", 8'h01, 8'h66, 8'hC3, 8'h5E);
  endtask

  initial begin
    waitC(5);
    rstN = 1'b1;
    waitC(5);
    tReset();
    tNotify();
    tIrq();
    tReadOnly();
    tFull();
    tW1c();
    tWrongAddr();
    tShortLong();
    tRestart();
    tGlitch();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule